// File: doc/BRIEF.md
# Kitchen Countdown Timer Controller

This block is the control core of a simple cooking timer. The user first presses an enter button to leave the ready state. Next the user chooses a cook time on a bank of switches and presses enter again to start the countdown. When the time runs out, the LED bank flashes until enter is pressed once more, which returns the controller to the ready state.

The raw push-button passes through a two-flop synchroniser and a debounce counter. The debounced level is then turned into a single-cycle pulse on its rising edge. A beat generator divides the clock to one beat per second. It restarts when a countdown begins, so the first second is a full second.

The remaining time is held directly in the LED register as a single lit bit. That bit moves one place to the right on every beat. The LEDs therefore show the time left, and the same register serves as the down-counter.

Top module: `cd_top`

## Requirements
- R1: A synchronous reset puts the controller in the ready state, with every LED lit. A reset in the middle of a countdown does the same.
- R2: Each accepted enter press moves ready to setup, setup to countdown, and flashing back to ready. Apart from the countdown exit, no other transition occurs.
- R3: In setup, the LEDs copy the switch bank, delayed by one clock.
- R4: On entry to the countdown, the LED register loads a single bit at position h-1, where h is the index of the highest set switch. All lower switches are ignored. If no switch is set, or only switch 0 is set, the register loads all zeros.
- R5: During the countdown, the lit bit moves right by one place on each beat, and enter has no effect.
- R6: When the register is all zeros, the next clock enters the flashing state with every LED lit. This happens h*BEAT_TICKS+1 clocks after countdown entry.
- R7: The beat is a one-clock pulse every BEAT_TICKS clocks. Its counter restarts on countdown entry.
- R8: In the flashing state, all LEDs invert together on each beat. The first inversion comes BEAT_TICKS-1 clocks after entry.
- R9: The enter level must stay steady for DEB_TICKS clocks after synchronisation before it is accepted. A shorter glitch is ignored, and a held press counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enter_raw | input | 1 | Undebounced enter button, active high |
| sw | input | LED_W | Switch bank selecting the cook time |
| led | output | LED_W | LED bank: ready, setting, time left or flash |

## Verification
The assertions assume that BEAT_TICKS and DEB_TICKS are at least 2. They also assume the switch bank is steady around the press that starts a countdown, so the loaded bit matches the pattern shown in setup. The stimulus changes the switches only while the controller is ready. It holds each press and each release well past the debounce window. It also uses a beat period longer than a full press, so a press made during a countdown falls between beats and cannot change the count.

// File: rtl/cd_pkg.sv
package cd_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_COOK  = 2'd1,
        ST_SET   = 2'd2,
        ST_FLASH = 2'd3
    } cd_state_e;
endpackage

// File: rtl/cd_debounce.sv
module cd_debounce #(
    parameter int DEB_TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_o
);
    localparam int DCW = $clog2(DEB_TICKS);
    localparam logic [DCW-1:0] LAST = DCW'(DEB_TICKS - 1);

    typedef struct packed {
        logic           s1;
        logic           s2;
        logic           level;
        logic [DCW-1:0] cnt;
        logic           press;
    } deb_t;

    deb_t d_d, d_q;

    always_comb begin
        d_d       = d_q;
        d_d.s1    = btn_raw;
        d_d.s2    = d_q.s1;
        d_d.press = 1'b0;
        if (d_q.s2 == d_q.level) begin
            d_d.cnt = '0;
        end else if (d_q.cnt == LAST) begin
            d_d.level = d_q.s2;
            d_d.cnt   = '0;
            d_d.press = d_q.s2;
        end else begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign press_o = d_q.press;

    p_press_single_r9: assert property (@(posedge clk) disable iff (rst)
        d_q.press |=> !d_q.press);
    p_press_needs_level_r9: assert property (@(posedge clk) disable iff (rst)
        d_q.press |-> d_q.level);
endmodule

// File: rtl/cd_beat.sv
module cd_beat #(
    parameter int BEAT_TICKS = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic beat_o
);
    localparam int BCW = $clog2(BEAT_TICKS);
    localparam logic [BCW-1:0] LAST = BCW'(BEAT_TICKS - 1);

    logic [BCW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i || beat_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign beat_o = (cnt_q == LAST);

    p_beat_single_r7: assert property (@(posedge clk) disable iff (rst)
        beat_o |=> !beat_o);
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !beat_o);
endmodule

// File: rtl/cd_ctrl.sv
module cd_ctrl
    import cd_pkg::*;
#(
    parameter int LED_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             press_i,
    input  logic             beat_i,
    input  logic [LED_W-1:0] sw,
    output logic             restart_o,
    output logic [LED_W-1:0] led
);
    typedef struct packed {
        cd_state_e        state;
        logic [LED_W-1:0] led;
    } ctrl_t;

    localparam ctrl_t RESET_VAL = '{state: ST_READY, led: '1};

    ctrl_t c_d, c_q;
    logic [LED_W-1:0] top_bit, load_val;

    always_comb begin
        top_bit = '0;
        for (int i = 0; i < LED_W; i++) begin
            if (sw[i]) top_bit = LED_W'(1) << i;
        end
        load_val = top_bit >> 1;
    end

    always_comb begin
        c_d       = c_q;
        restart_o = 1'b0;
        case (c_q.state)
            ST_READY: begin
                c_d.led = '1;
                if (press_i) c_d.state = ST_SET;
            end
            ST_SET: begin
                if (press_i) begin
                    c_d.state = ST_COOK;
                    c_d.led   = load_val;
                    restart_o = 1'b1;
                end else begin
                    c_d.led = sw;
                end
            end
            ST_COOK: begin
                if (c_q.led == '0) begin
                    c_d.state = ST_FLASH;
                    c_d.led   = '1;
                end else if (beat_i) begin
                    c_d.led = c_q.led >> 1;
                end
            end
            default: begin
                if (press_i) begin
                    c_d.state = ST_READY;
                    c_d.led   = '1;
                end else if (beat_i) begin
                    c_d.led = ~c_q.led;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= RESET_VAL;
        else     c_q <= c_d;
    end

    assign led = c_q.led;

    p_ready_lit_r1: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_READY) |-> (&c_q.led));
    p_flash_waits_r2: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_FLASH && !press_i) |=> (c_q.state == ST_FLASH));
    p_cook_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_COOK) |-> $onehot0(c_q.led));
    p_cook_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_COOK && c_q.led != '0) |=> (c_q.state == ST_COOK));
    p_cook_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_COOK && beat_i && c_q.led != '0) |=> (c_q.led == ($past(c_q.led) >> 1)));
    p_cook_done_r6: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_COOK && c_q.led == '0) |=> (c_q.state == ST_FLASH && (&c_q.led)));
    p_flash_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == ST_FLASH && beat_i && !press_i) |=> (c_q.led == ~$past(c_q.led)));
endmodule

// File: rtl/cd_top.sv
module cd_top #(
    parameter int LED_W      = 16,
    parameter int BEAT_TICKS = 100_000_000,
    parameter int DEB_TICKS  = 1_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter_raw,
    input  logic [LED_W-1:0] sw,
    output logic [LED_W-1:0] led
);
    logic press, beat, restart;

    cd_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst(rst), .btn_raw(enter_raw), .press_o(press)
    );

    cd_beat #(.BEAT_TICKS(BEAT_TICKS)) u_beat (
        .clk(clk), .rst(rst), .restart_i(restart), .beat_o(beat)
    );

    cd_ctrl #(.LED_W(LED_W)) u_ctrl (
        .clk(clk), .rst(rst), .press_i(press), .beat_i(beat),
        .sw(sw), .restart_o(restart), .led(led)
    );
endmodule

// File: tb/tb_cd_top.sv
`timescale 1ns/1ps
module tb_cd_top;
    localparam int W    = 16;
    localparam int TH   = 40;
    localparam int DEB  = 8;
    localparam int HOLD = DEB + 10;
    localparam int NV   = 5;
    localparam logic [W-1:0] SW_TAB [NV] = '{16'h0080, 16'h0031, 16'h0001, 16'h8000, 16'h0000};
    localparam bit COOK_PRESS [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_raw = 1'b0;
    logic [W-1:0] sw = '0;
    logic [W-1:0] led;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cd_top #(.LED_W(W), .BEAT_TICKS(TH), .DEB_TICKS(DEB)) dut (
        .clk(clk), .rst(rst), .enter_raw(enter_raw), .sw(sw), .led(led)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press();
        enter_raw = 1'b1;
        cyc(HOLD);
        enter_raw = 1'b0;
        cyc(HOLD);
    endtask

    task automatic run_cook(input logic [W-1:0] val, input bit cook_press);
        int n = 0;
        int cnt = 0;
        int guard = 0;
        logic [W-1:0] exp_load;
        for (int b = 0; b < W; b++) if (val[b]) n = b;
        exp_load = (n == 0) ? '0 : (W'(1) << (n - 1));
        if (val == '0) begin
            while (led != ONES && guard < 80) begin cyc(1); guard++; end
            chk(led == ONES, "R4 empty switches go straight to flash", led, ONES);
        end else begin
            while (led == val && guard < 80) begin cyc(1); guard++; end
            chk(led == exp_load, "R4 countdown load value", led, exp_load);
            while (led != ONES && cnt <= n * TH + 50) begin
                cyc(1);
                cnt++;
                if (cook_press && cnt == TH + TH / 2) enter_raw = 1'b1;
                if (cook_press && cnt == TH + TH / 2 + HOLD) enter_raw = 1'b0;
                if (led != ONES && (cnt % TH) == TH / 2 && (cnt / TH) < n)
                    chk(led == (W'(1) << (n - 1 - cnt / TH)), "R5 lit bit per beat", led,
                        W'(1) << (n - 1 - cnt / TH));
            end
            chk(cnt == n * TH + 1, "R6 R7 countdown length", W'(cnt), W'(n * TH + 1));
        end
        cyc(TH / 2);
        chk(led == ONES, "R8 flash starts lit", led, ONES);
        cyc(TH);
        chk(led == '0, "R8 flash inverts on beat", led, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=finish", total);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        chk(led == ONES, "R1 reset lights all", led, ONES);

        // R9: glitch shorter than the debounce window is ignored
        sw = 16'h0F0F;
        enter_raw = 1'b1;
        cyc(3);
        enter_raw = 1'b0;
        cyc(30);
        chk(led == ONES, "R9 glitch ignored", led, ONES);

        for (int v = 0; v < NV; v++) begin
            sw = SW_TAB[v];
            cyc(2);
            chk(led == ONES, "R2 ready before setup", led, ONES);
            press();
            chk(led == SW_TAB[v], "R3 R9 setup mirrors switches after one press", led, SW_TAB[v]);
            fork
                press();
                run_cook(SW_TAB[v], COOK_PRESS[v]);
            join
            press();
            chk(led == ONES, "R2 flash back to ready", led, ONES);
        end

        // R1: reset during a countdown
        sw = 16'h0400;
        press();
        press();
        cyc(50);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk(led == ONES, "R1 reset mid countdown", led, ONES);
        press();
        chk(led == 16'h0400, "R2 setup after reset", led, 16'h0400);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule